// File: doc/BRIEF.md
# Three-Wire Clock/Calendar Command Port

This block is the slave-side serial front end of a clock/calendar register file. A host selects the port with a chip-select line and clocks bits with a serial clock. Data travels on one bidirectional open-drain line. All three pins are brought into the system clock domain through a flop synchronizer, and edges on the serial clock are detected there. The serial clock must therefore run well below the system clock.

Each transfer opens with one command byte, sent first bit first. It holds a four-bit preamble `0110`, a three-bit operation code and a direction bit (1 = read, 0 = write). The operation code selects a register group and the number of bytes that follow. Those bytes then travel least significant bit first. Incoming bytes become write strobes toward the register file. For a read, the block presents a group/index address, takes the byte back combinationally, and shifts it out. The block also owns two pieces of control state: a test flag, which is overlaid onto bit 7 of the seconds byte on read, and a pulse that clears a latched power-fail flag when the status byte is read.

Top module: `tw_rtc_port`

## Requirements
- R1: A command byte whose upper four bits (the first four sent) differ from `0110` does nothing. No write strobe, no data-line drive and no control pulse follow, up to chip-select low.
- R2: If chip select falls before the eighth rising serial-clock edge, nothing is executed.
- R3: A write (direction bit 0) moves a number of bytes that depends on the opcode: opcode 001 moves 1 byte, 010 moves 7, 011 moves 3, and 100 and 101 move 2 each. Each byte is sampled on rising serial-clock edges, LSB first. Each byte gives one single-cycle `rf_wr_o` pulse with `rf_sel_o` equal to the opcode and `rf_idx_o` equal to the byte position from 0. Clocks beyond the last byte are ignored.
- R4: A read (direction bit 1) leaves `sio_oe_o` low until the first falling serial-clock edge after the command. From that edge on, each falling edge drives the next bit, LSB first. `sio_oe_o` drops again on the falling edge that follows the last bit.
- R5: Each read byte equals `rf_rdata_i` taken while `rf_sel_o` holds the opcode and `rf_idx_o` holds the byte position.
- R6: Opcode 000 raises `cmd_reset_o` for one cycle whatever the direction bit is. It clears the test flag and moves no data.
- R7: A status read (opcode 001, direction 1) raises `pwr_clr_o` for exactly one cycle. The returned status byte is captured before that pulse can act. A status write gives no pulse.
- R8: Opcode 110 sets `test_flag_o` and opcode 111 clears it. On read, the seconds byte (position 6 of opcode 010, position 2 of opcode 011) returns the test flag in bit 7 and the register-file bits in bits 6:0.
- R9: While chip select is low, `sio_oe_o` is low and serial-clock edges have no effect. Dropping chip select in the middle of a transfer ends it.
- R10: After reset, `sio_oe_o`, `rf_wr_o`, `cmd_reset_o`, `pwr_clr_o` and `test_flag_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, high selects the port |
| sck_i | input | 1 | Serial clock from the host |
| sio_i | input | 1 | Serial data line as seen at the pin |
| sio_out_o | output | 1 | Bit to present on the data line during a read |
| sio_oe_o | output | 1 | Data-line drive enable |
| rf_sel_o | output | 3 | Register group (the opcode) |
| rf_idx_o | output | 3 | Byte position within the group |
| rf_wr_o | output | 1 | Single-cycle write strobe |
| rf_wdata_o | output | 8 | Byte to write |
| rf_rdata_i | input | 8 | Byte read back for the current group/position |
| cmd_reset_o | output | 1 | Single-cycle calendar reset request |
| pwr_clr_o | output | 1 | Single-cycle clear of the latched power-fail flag |
| test_flag_o | output | 1 | Test flag level |

## Verification
A wrong byte or bit counter shows on the next transfer as a strobe at the wrong position, or as one strobe too many or too few. A wrong counter in a read shows as data shifted by a bit or a byte, or as the drive enable outlasting the last bit by one serial-clock edge. A command state that misses the chip-select fall would keep the line driven, or let clocks sent while deselected act. A per-clock monitor catches that within a few system cycles. A bad test flag or a missing power-clear pulse shows in the very next seconds-byte or status read.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned SEC_ALL = 6;
  localparam int unsigned SEC_HMS = 2;
  localparam logic [3:0]  PREAMBLE = 4'b0110;

  typedef enum logic [2:0] {
    OP_RESET    = 3'd0,
    OP_STATUS   = 3'd1,
    OP_TIME_ALL = 3'd2,
    OP_TIME_HMS = 3'd3,
    OP_ALARM1   = 3'd4,
    OP_ALARM2   = 3'd5,
    OP_TEST_ON  = 3'd6,
    OP_TEST_OFF = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_WR, ST_RD, ST_SKIP
  } st_e;

  typedef struct packed {
    logic             hit;
    op_e              op;
    logic             rd;
    logic [IDX_W-1:0] nbytes;
    logic             do_reset;
    logic             test_on;
    logic             test_off;
    logic             pwr_clr;
  } cmd_t;
endpackage

// File: rtl/tw_sync.sv
`timescale 1ns/1ps
module tw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [STAGES:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[STAGES-1:0], d_i};
  end

  assign q_o      = stg_q[STAGES-1];
  assign q_prev_o = stg_q[STAGES];
endmodule

// File: rtl/tw_decode.sv
`timescale 1ns/1ps
module tw_decode
  import tw_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output cmd_t              cmd_o
);
  always_comb begin
    cmd_o.hit = (byte_i[BYTE_W-1:BYTE_W-4] == PREAMBLE);
    cmd_o.op  = op_e'(byte_i[3:1]);
    cmd_o.rd  = byte_i[0];
    unique case (cmd_o.op)
      OP_STATUS:            cmd_o.nbytes = IDX_W'(1);
      OP_TIME_ALL:          cmd_o.nbytes = IDX_W'(7);
      OP_TIME_HMS:          cmd_o.nbytes = IDX_W'(3);
      OP_ALARM1, OP_ALARM2: cmd_o.nbytes = IDX_W'(2);
      default:              cmd_o.nbytes = '0;
    endcase
    cmd_o.do_reset = cmd_o.hit && (cmd_o.op == OP_RESET);
    cmd_o.test_on  = cmd_o.hit && (cmd_o.op == OP_TEST_ON);
    cmd_o.test_off = cmd_o.hit && (cmd_o.op == OP_TEST_OFF);
    cmd_o.pwr_clr  = cmd_o.hit && (cmd_o.op == OP_STATUS) && cmd_o.rd;
  end
endmodule

// File: rtl/tw_rtc_port.sv
`timescale 1ns/1ps
module tw_rtc_port
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              sck_i,
  input  logic              sio_i,
  output logic              sio_out_o,
  output logic              sio_oe_o,
  output logic [2:0]        rf_sel_o,
  output logic [IDX_W-1:0]  rf_idx_o,
  output logic              rf_wr_o,
  output logic [BYTE_W-1:0] rf_wdata_o,
  input  logic [BYTE_W-1:0] rf_rdata_i,
  output logic              cmd_reset_o,
  output logic              pwr_clr_o,
  output logic              test_flag_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  // pin synchronizer: bit 2 = data, bit 1 = clock, bit 0 = select
  logic [2:0] pin_s, pin_p;
  tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({sio_i, sck_i, cs_i}),
    .q_o(pin_s), .q_prev_o(pin_p)
  );

  logic cs_s, cs_p, sck_s, sck_p, sio_s;
  assign cs_s  = pin_s[0];
  assign cs_p  = pin_p[0];
  assign sck_s = pin_s[1];
  assign sck_p = pin_p[1];
  assign sio_s = pin_s[2];

  logic sck_rise, sck_fall, cs_rise, cs_fall;
  assign sck_rise = cs_s &  sck_s & ~sck_p;
  assign sck_fall = cs_s & ~sck_s &  sck_p;
  assign cs_rise  =  cs_s & ~cs_p;
  assign cs_fall  = ~cs_s &  cs_p;

  st_e               st_q, st_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d, nb_q, nb_d;
  op_e               sel_q, sel_d;
  logic [BYTE_W-1:0] sh_q, sh_d, wdata_q, wdata_d;
  logic [BYTE_W-2:0] cmd_q, cmd_d;
  logic              out_q, out_d, oe_q, oe_d, wr_q, wr_d, load_q, load_d;
  logic              rstp_q, rstp_d, clr_q, clr_d, test_q, test_d;

  // command decode on the byte completed by the current bit
  logic [BYTE_W-1:0] dec_in;
  cmd_t              dec;
  assign dec_in = {cmd_q, sio_s};
  tw_decode u_dec (.byte_i(dec_in), .cmd_o(dec));

  logic              sec_byte;
  logic [IDX_W:0]    idx_inc;
  assign sec_byte = ((sel_q == OP_TIME_ALL) && (idx_q == IDX_W'(SEC_ALL))) ||
                    ((sel_q == OP_TIME_HMS) && (idx_q == IDX_W'(SEC_HMS)));
  assign idx_inc  = {1'b0, idx_q} + 1'b1;

  always_comb begin
    st_d    = st_q;   bcnt_d = bcnt_q; idx_d  = idx_q;  nb_d   = nb_q;
    sel_d   = sel_q;  sh_d   = sh_q;   cmd_d  = cmd_q;  out_d  = out_q;
    oe_d    = oe_q;   wdata_d = wdata_q; test_d = test_q;
    wr_d    = 1'b0;   load_d = 1'b0;   rstp_d = 1'b0;   clr_d  = 1'b0;

    if (load_q)
      sh_d = sec_byte ? {test_q, rf_rdata_i[BYTE_W-2:0]} : rf_rdata_i;

    if (wr_q) begin
      idx_d = idx_inc[IDX_W-1:0];
      if (idx_inc == {1'b0, nb_q}) st_d = ST_SKIP;
    end

    if (cs_fall) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cs_rise) begin
          st_d   = ST_CMD;
          bcnt_d = '0;
        end
        ST_CMD: if (sck_rise) begin
          cmd_d  = dec_in[BYTE_W-2:0];
          bcnt_d = bcnt_q + 1'b1;
          if (bcnt_q == CNT_W'(BYTE_W-1)) begin
            idx_d = '0;
            sel_d = dec.op;
            nb_d  = dec.nbytes;
            if (!dec.hit) st_d = ST_SKIP;
            else if (dec.do_reset) begin
              rstp_d = 1'b1; test_d = 1'b0; st_d = ST_SKIP;
            end else if (dec.test_on) begin
              test_d = 1'b1; st_d = ST_SKIP;
            end else if (dec.test_off) begin
              test_d = 1'b0; st_d = ST_SKIP;
            end else if (dec.rd) begin
              st_d = ST_RD; load_d = 1'b1; clr_d = dec.pwr_clr;
            end else st_d = ST_WR;
          end
        end
        ST_WR: if (sck_rise) begin
          sh_d   = {sio_s, sh_q[BYTE_W-1:1]};
          bcnt_d = bcnt_q + 1'b1;
          if (bcnt_q == CNT_W'(BYTE_W-1)) begin
            wr_d    = 1'b1;
            wdata_d = {sio_s, sh_q[BYTE_W-1:1]};
          end
        end
        ST_RD: if (sck_fall) begin
          if (idx_q == nb_q) begin
            st_d = ST_SKIP;
            oe_d = 1'b0;
          end else begin
            oe_d   = 1'b1;
            out_d  = sh_q[bcnt_q];
            bcnt_d = bcnt_q + 1'b1;
            if (bcnt_q == CNT_W'(BYTE_W-1)) begin
              idx_d  = idx_inc[IDX_W-1:0];
              load_d = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; bcnt_q <= '0; idx_q <= '0; nb_q <= '0;
      sel_q <= OP_RESET; sh_q <= '0; cmd_q <= '0; out_q <= 1'b0;
      oe_q <= 1'b0; wr_q <= 1'b0; wdata_q <= '0; load_q <= 1'b0;
      rstp_q <= 1'b0; clr_q <= 1'b0; test_q <= 1'b0;
    end else begin
      st_q <= st_d; bcnt_q <= bcnt_d; idx_q <= idx_d; nb_q <= nb_d;
      sel_q <= sel_d; sh_q <= sh_d; cmd_q <= cmd_d; out_q <= out_d;
      oe_q <= oe_d; wr_q <= wr_d; wdata_q <= wdata_d; load_q <= load_d;
      rstp_q <= rstp_d; clr_q <= clr_d; test_q <= test_d;
    end
  end

  assign sio_out_o   = out_q;
  assign sio_oe_o    = oe_q;
  assign rf_sel_o    = sel_q;
  assign rf_idx_o    = idx_q;
  assign rf_wr_o     = wr_q;
  assign rf_wdata_o  = wdata_q;
  assign cmd_reset_o = rstp_q;
  assign pwr_clr_o   = clr_q;
  assign test_flag_o = test_q;

  p_oe_off_cs_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !cs_p) |-> !sio_oe_o);
  p_wr_not_reading_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_o |-> !sio_oe_o);
  p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_o |=> !rf_wr_o);
  p_wr_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_o |-> ({1'b0, rf_idx_o} < {1'b0, nb_q}));
  p_oe_only_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sio_oe_o |-> (st_q == ST_RD));
  p_out_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_oe_o && !$stable(sio_out_o)) |-> $past(sck_fall));
  p_reset_clears_test_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset_o |-> !test_flag_o);
  p_clr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_clr_o |=> !pwr_clr_o);
endmodule

// File: tb/sim_tw_rtc_port.sv
`timescale 1ns/1ps
module sim_tw_rtc_port;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, sio = 1'b0;
  logic sio_out, sio_oe, rf_wr, cmd_reset, pwr_clr, test_flag;
  logic [2:0] rf_sel, rf_idx;
  logic [7:0] rf_wdata, rf_rdata;

  int nchk = 0, nerr = 0, n_rst = 0, n_clr = 0, mon_err = 0, cs_low = 0;
  bit done = 1'b0;
  logic [13:0] wq[$];

  always #5 clk = ~clk;

  function automatic logic [7:0] rd_val(logic [2:0] s, logic [2:0] i);
    return {i, s, 2'b11} ^ 8'h24;
  endfunction
  assign rf_rdata = rd_val(rf_sel, rf_idx);

  tw_rtc_port u0 (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .sio_i(sio),
    .sio_out_o(sio_out), .sio_oe_o(sio_oe), .rf_sel_o(rf_sel), .rf_idx_o(rf_idx),
    .rf_wr_o(rf_wr), .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata),
    .cmd_reset_o(cmd_reset), .pwr_clr_o(pwr_clr), .test_flag_o(test_flag)
  );

  // per-clock reference monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rf_wr) wq.push_back({rf_sel, rf_idx, rf_wdata});
    if (cmd_reset) n_rst++;
    if (pwr_clr) n_clr++;
    if (!cs) cs_low++; else cs_low = 0;
    if (rst_n && cs_low > 4 && (sio_oe || rf_wr)) mon_err++;
  end

  task automatic check(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hp; repeat (8) @(negedge clk); endtask
  task automatic open_x; cs = 1'b1; hp(); endtask
  task automatic close_x; sck = 1'b0; hp(); cs = 1'b0; hp(); hp(); endtask
  task automatic send_bit(logic b); sck = 1'b0; sio = b; hp(); sck = 1'b1; hp(); endtask
  task automatic send_cmd(logic [2:0] op, logic rw);
    logic [7:0] c = {4'b0110, op, rw};
    for (int i = 7; i >= 0; i--) send_bit(c[i]);
  endtask
  task automatic send_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic do_write(logic [2:0] op, int n, string tag);
    wq.delete();
    open_x(); send_cmd(op, 1'b0);
    for (int k = 0; k < n; k++) send_byte(8'(8'h31 + k * 17));
    send_byte(8'hFF);
    close_x();
    check(wq.size() == n, tag, wq.size(), n);
    for (int k = 0; k < n && k < wq.size(); k++)
      check(wq[k] == {op, 3'(k), 8'(8'h31 + k * 17)}, tag, wq[k], {op, 3'(k), 8'(8'h31 + k * 17)});
  endtask

  task automatic do_read(logic [2:0] op, int n, string tag);
    logic [7:0] got, exp;
    int oe_bad = 0;
    open_x(); send_cmd(op, 1'b1);
    check(sio_oe == 1'b0, "R4 oe before data", sio_oe, 0);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        sck = 1'b0; hp(); got[i] = sio_out; if (!sio_oe) oe_bad++;
        sck = 1'b1; hp();
      end
      exp = rd_val(op, 3'(k));
      if ((op == 3'd2 && k == 6) || (op == 3'd3 && k == 2)) exp[7] = test_flag;
      check(got == exp, tag, got, exp);
    end
    check(oe_bad == 0, "R4 oe during data", oe_bad, 0);
    sck = 1'b0; hp();
    check(sio_oe == 1'b0, "R4 oe after last bit", sio_oe, 0);
    close_x();
  endtask

  initial begin
    int r0, c0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({sio_oe, rf_wr, cmd_reset, pwr_clr, test_flag} == 5'b0, "R10 reset state",
          {sio_oe, rf_wr, cmd_reset, pwr_clr, test_flag}, 0);

    c0 = n_clr;
    do_write(3'd1, 1, "R3 status write");
    check(n_clr == c0, "R7 no clear on write", n_clr - c0, 0);
    do_write(3'd2, 7, "R3 full time write");
    do_write(3'd3, 3, "R3 hms write");
    do_write(3'd4, 2, "R3 alarm1 write");
    do_write(3'd5, 2, "R3 alarm2 write");

    do_read(3'd2, 7, "R5 full time read");
    c0 = n_clr;
    do_read(3'd1, 1, "R5 status read");
    check(n_clr == c0 + 1, "R7 clear pulse", n_clr - c0, 1);

    // R1: wrong preamble
    wq.delete(); r0 = n_rst; c0 = n_clr;
    open_x();
    for (int i = 7; i >= 0; i--) send_bit(i == 7 ? 1'b1 : (8'b1110_0011 >> i) & 1);
    send_byte(8'hA5);
    for (int i = 0; i < 4; i++) begin
      sck = 1'b0; hp();
      check(sio_oe == 1'b0, "R1 no drive", sio_oe, 0);
      sck = 1'b1; hp();
    end
    close_x();
    check(wq.size() == 0 && n_rst == r0 && n_clr == c0, "R1 no op", wq.size(), 0);

    // R2: short command
    wq.delete(); r0 = n_rst;
    open_x();
    for (int i = 7; i >= 3; i--) send_bit(((8'b0110_0000) >> i) & 1);
    close_x();
    check(n_rst == r0 && wq.size() == 0, "R2 short command", n_rst - r0, 0);

    // R6: reset with either direction
    r0 = n_rst;
    open_x(); send_cmd(3'd6, 1'b0); close_x();
    check(test_flag == 1'b1, "R8 test on", test_flag, 1);
    open_x(); send_cmd(3'd0, 1'b1); close_x();
    check(n_rst == r0 + 1, "R6 reset rw=1", n_rst - r0, 1);
    check(test_flag == 1'b0, "R6 test cleared", test_flag, 0);
    open_x(); send_cmd(3'd0, 1'b0); close_x();
    check(n_rst == r0 + 2, "R6 reset rw=0", n_rst - r0, 2);

    // R8: test flag overlay on seconds byte
    open_x(); send_cmd(3'd6, 1'b1); close_x();
    check(test_flag == 1'b1, "R8 test on again", test_flag, 1);
    do_read(3'd3, 3, "R8 hms read with flag");
    open_x(); send_cmd(3'd7, 1'b0); close_x();
    check(test_flag == 1'b0, "R8 test off", test_flag, 0);
    do_read(3'd2, 7, "R8 full read flag clear");

    // R9: clocks with select low, then drop select mid-read
    wq.delete();
    for (int i = 0; i < 12; i++) send_bit(i[0]);
    check(wq.size() == 0 && sio_oe == 1'b0, "R9 deselected clocks", wq.size(), 0);
    open_x(); send_cmd(3'd2, 1'b1);
    for (int i = 0; i < 3; i++) begin sck = 1'b0; hp(); sck = 1'b1; hp(); end
    check(sio_oe == 1'b1, "R4 oe mid read", sio_oe, 1);
    cs = 1'b0; repeat (5) @(negedge clk);
    check(sio_oe == 1'b0, "R9 drop ends read", sio_oe, 0);
    sck = 1'b0; hp(); hp();
    do_write(3'd4, 2, "R9 next transfer after drop");

    check(mon_err == 0, "R9 per-clock monitor", mon_err, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule